// File: doc/BRIEF.md
# Snapshot Priority Arbiter

This block grants one of several requesters access to a single shared output port. Arbitration happens in two phases. When the port is free and at least one request line is high, a lock flag rises and freezes the current request pattern in a lock register. The priority values are frozen with it. On the following cycle, the block picks a winner from that frozen pattern only and asserts its grant. The grant stays high until the shared resource pulses a release input. The lock then drops and can close again on the next cycle.

A request that rises while the lock is high has lost against the lock. It is left out of the current decision and waits for the next lock window. Requests that arrive while the port is busy accumulate, and the highest-priority one among them wins when the lock next closes. A parameter chooses where priorities come from:

- **Dynamic:** each channel supplies its value on a priority bus.
- **Fixed:** priority is set by channel position, and the lowest index always wins.

Top module: `snap_arbiter`

## Requirements
- R1: After reset, every grant bit and the lock output are low.
- R2: While the lock is low and at least one request is high at a clock edge, the lock is high after that edge. The request pattern and the priority bus at that edge are latched.
- R3: One cycle after the lock rises, the grant goes to the latched requester with the largest priority value. Channel i's priority is the unsigned field at bits [i*PW +: PW] of the priority bus. Priority changes after the lock edge have no effect on that grant.
- R4: When latched requesters share the largest priority value, the lowest channel index wins.
- R5: A request first raised while the lock is high is not part of the current snapshot and receives no grant from it.
- R6: At most one grant bit is high at a time. A grant holds unchanged while release is low. A release pulse during a grant clears the grant and the lock at the same edge.
- R7: Requests held during a grant are latched at the first edge after the release edge. The highest-priority one among them is granted.
- R8: Release has no effect while no grant is asserted, whether the block is idle or in the cycle between lock and grant.
- R9: With FIXED_PRIO=1 the priority bus is ignored, and the lowest-indexed latched requester wins.
- R10: A grant bit only rises for a channel whose request was latched at the preceding lock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | NCH | Request per channel |
| prio_i | input | NCH*PW | Priority value per channel, PW bits each, channel 0 in the low bits |
| release_i | input | 1 | Pulse from the shared resource ending the current grant |
| lock_o | output | 1 | High while a request snapshot is held |
| grant_o | output | NCH | One-hot grant |

## Verification
The bench builds two copies, both with four channels and three-bit priorities. One copy takes priorities from the bus and the other uses fixed positional priority. Both see the same stimulus, so a single table of patterns exercises maximum selection, ties, a single requester and all-zero priorities in both modes. Four channels with three-bit priorities are enough to set up a strict winner in an upper channel, a tie among several channels and a late request with a higher value than the latched ones. The directed tests cover the cycle around the lock edge: a late arrival, a priority change after the lock, a release during the evaluation cycle and requests pending at release.

// File: rtl/snap_arbiter.sv
module snap_arbiter #(
  parameter int NCH        = 4,
  parameter int PW         = 3,
  parameter bit FIXED_PRIO = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    req_i,
  input  logic [NCH*PW-1:0] prio_i,
  input  logic              release_i,
  output logic              lock_o,
  output logic [NCH-1:0]    grant_o
);
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

  logic              lock_q;
  logic [NCH-1:0]    snap_q;
  logic [NCH*PW-1:0] prio_q;
  logic [NCH*PW-1:0] prio_cap;
  logic [NCH-1:0]    grant_q;
  logic [NCH-1:0]    win;
  logic              busy;

  generate
    if (FIXED_PRIO) begin : g_fixed
      assign prio_cap = '0;
    end else begin : g_dyn
      assign prio_cap = prio_i;
    end
  endgenerate

  assign busy    = |grant_q;
  assign lock_o  = lock_q;
  assign grant_o = grant_q;

  always_comb begin
    logic [PW-1:0] best;
    logic [IW-1:0] idx;
    logic          found;
    best  = '0;
    idx   = '0;
    found = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (snap_q[i] && (!found || prio_q[i*PW +: PW] > best)) begin
        best  = prio_q[i*PW +: PW];
        idx   = IW'(i);
        found = 1'b1;
      end
    end
    win = '0;
    if (found) win[idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q  <= 1'b0;
      snap_q  <= '0;
      prio_q  <= '0;
      grant_q <= '0;
    end else if (!lock_q) begin
      if (|req_i) begin
        lock_q <= 1'b1;
        snap_q <= req_i;
        prio_q <= prio_cap;
      end
    end else if (!busy) begin
      grant_q <= win;
    end else if (release_i) begin
      grant_q <= '0;
      lock_q  <= 1'b0;
      snap_q  <= '0;
    end
  end

  p_onehot_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  p_grant_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant_o && !release_i) |=> $stable(grant_o));

  p_release_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant_o && release_i) |=> (grant_o == '0 && !lock_o));

  p_lock_on_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_o && |req_i) |=> lock_o);

  p_grant_after_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_o && grant_o == '0) |=> (grant_o != '0));

  p_grant_in_snapshot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o & ~snap_q) == '0);

  p_idle_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_o && release_i && req_i == '0) |=> (!lock_o && grant_o == '0));
endmodule

// File: tb/snap_arbiter_tb.sv
module snap_arbiter_tb;
  localparam int NCH = 4;
  localparam int PW  = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NCH-1:0]    req = '0;
  logic [NCH*PW-1:0] prio = '0;
  logic              rel = 1'b0;
  logic              lock_d, lock_f;
  logic [NCH-1:0]    gnt_d, gnt_f;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  snap_arbiter #(.NCH(NCH), .PW(PW), .FIXED_PRIO(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .prio_i(prio), .release_i(rel),
    .lock_o(lock_d), .grant_o(gnt_d));

  snap_arbiter #(.NCH(NCH), .PW(PW), .FIXED_PRIO(1'b1)) u_dut_fix (
    .clk(clk), .rst_n(rst_n), .req_i(req), .prio_i(prio), .release_i(rel),
    .lock_o(lock_f), .grant_o(gnt_f));

  // {request pattern, priorities ch3..ch0, expected dynamic grant}
  localparam logic [19:0] VEC [8] = '{
    {4'b0001, 12'b000_000_000_000, 4'b0001},
    {4'b1111, 12'b111_001_010_011, 4'b1000},
    {4'b0110, 12'b101_101_101_101, 4'b0010},
    {4'b1010, 12'b010_000_110_000, 4'b0010},
    {4'b1101, 12'b011_100_000_100, 4'b0001},
    {4'b0100, 12'b000_000_000_000, 4'b0100},
    {4'b1111, 12'b000_000_000_000, 4'b0001},
    {4'b1100, 12'b001_000_000_000, 4'b1000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [NCH-1:0] lowest(input logic [NCH-1:0] r);
    for (int i = 0; i < NCH; i++) if (r[i]) return NCH'(1) << i;
    return '0;
  endfunction

  task automatic finish_all();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #500us;
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: got hang expected completion");
    finish_all();
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    chk("R1 grant", 32'(gnt_d), 0);
    chk("R1 lock", 32'(lock_d), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 8; v++) begin
      req  = VEC[v][19:16];
      prio = VEC[v][15:4];
      step();
      chk("R2 lock", 32'(lock_d), 1);
      chk("R2 no early grant", 32'(gnt_d), 0);
      step();
      chk("R3 R4 grant", 32'(gnt_d), 32'(VEC[v][3:0]));
      chk("R9 fixed grant", 32'(gnt_f), 32'(lowest(VEC[v][19:16])));
      rel = 1'b1;
      req = '0;
      step();
      rel = 1'b0;
      chk("R6 release clears grant", 32'(gnt_d), 0);
      chk("R6 release clears lock", 32'(lock_d), 0);
    end

    // R8: release while idle
    rel = 1'b1;
    step();
    step();
    rel = 1'b0;
    chk("R8 idle release lock", 32'(lock_d), 0);
    chk("R8 idle release grant", 32'(gnt_d), 0);

    // R5: late request while lock is high
    req  = 4'b0001;
    prio = 12'b111_000_000_000;
    step();
    req = 4'b1001;
    step();
    chk("R5 late request excluded", 32'(gnt_d), 32'h1);

    // R6: grant held while release stays low
    for (int k = 0; k < 4; k++) begin
      step();
      chk("R6 grant held", 32'(gnt_d), 32'h1);
    end

    // R7: requests accumulated during a grant
    req  = 4'b0110;
    prio = 12'b000_110_010_000;
    step();
    rel = 1'b1;
    step();
    rel = 1'b0;
    chk("R7 lock reopened", 32'(lock_d), 0);
    step();
    chk("R7 relock", 32'(lock_d), 1);
    step();
    chk("R7 accumulated winner", 32'(gnt_d), 32'h4);
    chk("R9 fixed accumulated", 32'(gnt_f), 32'h2);
    req = '0;
    rel = 1'b1;
    step();
    rel = 1'b0;

    // R3/R8: priority change and release during the evaluation cycle
    req  = 4'b0011;
    prio = 12'b000_000_101_001;
    step();
    prio = 12'b000_000_101_111;
    rel  = 1'b1;
    step();
    rel = 1'b0;
    chk("R3 latched priority", 32'(gnt_d), 32'h2);
    chk("R8 eval release ignored", 32'(lock_d), 1);
    req = '0;
    rel = 1'b1;
    step();
    rel = 1'b0;
    chk("R6 final clear", 32'(gnt_d), 0);

    finish_all();
  end
endmodule